// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual address into a physical address by fetching one page table entry from memory. A requester presents a 14-bit virtual address together with the kind of access (read or write) and the privilege it runs at (user or kernel). The walker splits off the 8-bit virtual page number and scales it by the entry size. It adds the result to a table base value and issues a single memory read for that entry. When the entry returns, the walker checks it and answers with either a physical address or a fault code.

A page whose present bit is clear gives a not-present fault. A present page can still refuse an access. A user access to a kernel-only page, a write to a page without write permission, or a read from a page without read permission gives a protection fault. The walker keeps nothing between requests. A request retried after system software has edited the table always reads the entry again.

Top module: `ptw_top`

## Requirements
- R1: The entry read is issued at address `pt_base + vpn * PTE_BYTES`, where the VPN is virtual address bits [13:6] and PTE_BYTES is 2. `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready` is seen high.
- R2: Only one walk is in flight. `req_ready` is low from the cycle after a request is accepted until its response has been given. While a walk is under way, no second entry read is started.
- R3: Entry layout: bit 0 is present, bit 1 is kernel-only, bit 2 allows reads, bit 3 allows writes, and bits [9:4] hold the 6-bit physical page number. On success the fault code is 00 and `rsp_paddr` is the physical page number followed by virtual address bits [5:0] unchanged.
- R4: An entry with the present bit at 0 gives fault code 01 and `rsp_paddr` 0. This holds whatever the permission bits say, so not-present takes priority over protection.
- R5: A present entry with the kernel-only bit set gives fault code 10 and `rsp_paddr` 0 when `req_user` is 1. With `req_user` 0 the kernel-only bit has no effect.
- R6: A present entry gives fault code 10 and `rsp_paddr` 0 when `req_write` is 1 and the write bit is 0. It gives the same result when `req_write` is 0 and the read bit is 0.
- R7: Each accepted request produces exactly one `rsp_valid` pulse, one cycle long. The pulse comes in the cycle after the entry data is taken.
- R8: No translation is kept. Repeating a request after the entry in memory has changed gives the result for the new entry.
- R9: After reset, `req_ready` is 1, and `mem_req_valid` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pt_base | input | 12 | Byte address of the page table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 14 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_user | input | 1 | 1 for a user-mode access |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | 12 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data present |
| mem_rsp_data | input | 10 | Entry contents |
| rsp_valid | output | 1 | Translation result pulse |
| rsp_paddr | output | 12 | Physical address (0 on a fault) |
| rsp_fault | output | 2 | 00 ok, 01 not present, 10 protection |

## Verification
The bench builds the walker with its default sizes: 14-bit virtual and 12-bit physical addresses, 64-byte pages and 2-byte entries. These sizes keep the whole 256-entry table small enough to walk completely. Every page number is translated under all four pairings of read or write with user or kernel mode. Together the entries cover every mix of present, kernel-only, read and write bits, while the memory model varies its ready stalls and response delays. An entry is then made absent, looked up, made present again and looked up once more, to show that no stale translation survives.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_ABSENT = 2'b01,
    FLT_PROT   = 2'b10
  } fault_e;

  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_FETCH = 2'd1,
    WS_WAIT  = 2'd2,
    WS_DONE  = 2'd3
  } walk_state_e;

  // entry bit positions
  localparam int unsigned ENT_PRESENT = 0;
  localparam int unsigned ENT_KERNEL  = 1;
  localparam int unsigned ENT_RD      = 2;
  localparam int unsigned ENT_WR      = 3;
  localparam int unsigned ENT_FRAME   = 4;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int unsigned VPN_W     = 8,
  parameter int unsigned MEM_AW    = 12,
  parameter int unsigned PTE_BYTES = 2
) (
  input  logic [MEM_AW-1:0] base,
  input  logic [VPN_W-1:0]  vpn,
  output logic [MEM_AW-1:0] ent_addr
);
  localparam int unsigned SHIFT = $clog2(PTE_BYTES);

  function automatic logic [MEM_AW-1:0] entry_address(
      input logic [MEM_AW-1:0] b, input logic [VPN_W-1:0] v);
    logic [MEM_AW-1:0] scaled;
    scaled = MEM_AW'(v) << SHIFT;
    return b + scaled;
  endfunction

  assign ent_addr = entry_address(base, vpn);

  // R1: entries are aligned when the base is aligned
  always_comb begin
    if (SHIFT > 0 && base[0] == 1'b0)
      a_r1_aligned: assert (ent_addr[0] == 1'b0);
  end
endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
  import ptw_pkg::*;
#(
  parameter int unsigned PPN_W = 6,
  parameter int unsigned PTE_W = PPN_W + 4
) (
  input  logic [PTE_W-1:0] entry,
  input  logic             is_write,
  input  logic             is_user,
  output fault_e           fault,
  output logic [PPN_W-1:0] frame
);
  logic present, kernel_only, can_rd, can_wr;
  logic priv_bad, acc_bad;

  assign present     = entry[ENT_PRESENT];
  assign kernel_only = entry[ENT_KERNEL];
  assign can_rd      = entry[ENT_RD];
  assign can_wr      = entry[ENT_WR];
  assign frame       = entry[ENT_FRAME +: PPN_W];

  assign priv_bad = is_user & kernel_only;
  assign acc_bad  = is_write ? ~can_wr : ~can_rd;

  always_comb begin
    if (!present)                fault = FLT_ABSENT;
    else if (priv_bad | acc_bad) fault = FLT_PROT;
    else                         fault = FLT_NONE;
  end

  // R4 / R5 / R6: ordering of fault classes
  always_comb begin
    if (!present)
      a_r4_absent_first: assert (fault == FLT_ABSENT);
    if (present && is_user && kernel_only)
      a_r5_user_kernel_page: assert (fault == FLT_PROT);
    if (present && is_write && !can_wr)
      a_r6_write_denied: assert (fault == FLT_PROT);
  end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W  = 14,
  parameter int unsigned OFS_W = 6,
  parameter int unsigned PPN_W = 6,
  localparam int unsigned VPN_W = VA_W - OFS_W,
  localparam int unsigned PA_W  = PPN_W + OFS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  input  logic             req_user,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  input  logic             mem_rsp_valid,
  output logic [VPN_W-1:0] walk_vpn,
  output logic             walk_write,
  output logic             walk_user,
  input  fault_e           chk_fault,
  input  logic [PPN_W-1:0] chk_frame,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output fault_e           rsp_fault
);
  walk_state_e     st;
  logic [VA_W-1:0] va_q;
  logic            wr_q, usr_q;

  function automatic logic [PA_W-1:0] join_pa(
      input logic [PPN_W-1:0] f, input logic [OFS_W-1:0] o);
    return {f, o};
  endfunction

  // named events
  logic req_accept, pte_issue, pte_arrive;
  assign req_accept = req_valid & req_ready;
  assign pte_issue  = mem_req_valid & mem_req_ready;
  assign pte_arrive = (st == WS_WAIT) & mem_rsp_valid;

  assign req_ready     = (st == WS_IDLE);
  assign mem_req_valid = (st == WS_FETCH);
  assign rsp_valid     = (st == WS_DONE);
  assign walk_vpn      = va_q[VA_W-1:OFS_W];
  assign walk_write    = wr_q;
  assign walk_user     = usr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= WS_IDLE;
      va_q      <= '0;
      wr_q      <= 1'b0;
      usr_q     <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= FLT_NONE;
    end else begin
      unique case (st)
        WS_IDLE: if (req_accept) begin
          va_q  <= req_vaddr;
          wr_q  <= req_write;
          usr_q <= req_user;
          st    <= WS_FETCH;
        end
        WS_FETCH: if (pte_issue) st <= WS_WAIT;
        WS_WAIT: if (pte_arrive) begin
          rsp_fault <= chk_fault;
          rsp_paddr <= (chk_fault == FLT_NONE) ?
                       join_pa(chk_frame, va_q[OFS_W-1:0]) : '0;
          st        <= WS_DONE;
        end
        WS_DONE: st <= WS_IDLE;
        default: st <= WS_IDLE;
      endcase
    end
  end

  a_r1_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(walk_vpn));

  a_r2_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> !req_ready);

  a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault == FLT_NONE |-> rsp_paddr[OFS_W-1:0] == va_q[OFS_W-1:0]);

  a_r4_no_pa_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != FLT_NONE |-> rsp_paddr == '0);

  a_r7_after_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(mem_rsp_valid));

  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W      = 14,
  parameter int unsigned PA_W      = 12,
  parameter int unsigned OFS_W     = 6,
  parameter int unsigned PTE_BYTES = 2,
  localparam int unsigned VPN_W = VA_W - OFS_W,
  localparam int unsigned PPN_W = PA_W - OFS_W,
  localparam int unsigned PTE_W = PPN_W + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PA_W-1:0]  pt_base,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  input  logic             req_user,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_fault
);
  logic [VPN_W-1:0] walk_vpn;
  logic             walk_write, walk_user;
  fault_e           chk_fault, fault_q;
  logic [PPN_W-1:0] chk_frame;

  ptw_ctrl #(.VA_W(VA_W), .OFS_W(OFS_W), .PPN_W(PPN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid),
    .walk_vpn(walk_vpn), .walk_write(walk_write), .walk_user(walk_user),
    .chk_fault(chk_fault), .chk_frame(chk_frame),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(fault_q)
  );

  ptw_addr_gen #(.VPN_W(VPN_W), .MEM_AW(PA_W), .PTE_BYTES(PTE_BYTES)) u_addr (
    .base(pt_base), .vpn(walk_vpn), .ent_addr(mem_req_addr)
  );

  ptw_perm_check #(.PPN_W(PPN_W), .PTE_W(PTE_W)) u_perm (
    .entry(mem_rsp_data), .is_write(walk_write), .is_user(walk_user),
    .fault(chk_fault), .frame(chk_frame)
  );

  assign rsp_fault = fault_q;

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready && !rsp_valid);

  a_r4_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault != 2'b11);
endmodule

// File: tb/tb_ptw_top.sv
module tb_ptw_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] pt_base = 12'h200;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [13:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [11:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [9:0]  mem_rsp_data = '0;
  logic        rsp_valid;
  logic [11:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  ptw_top dut (
    .clk(clk), .rst_n(rst_n), .pt_base(pt_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );

  // table image: {frame[5:0], wr, rd, kernel, present}
  logic [9:0] tbl [256];
  logic [11:0] exp_addr;

  function automatic logic [9:0] make_entry(input int v);
    logic p, k, r, w;
    logic [5:0] f;
    p = (v % 5) != 0;
    k = v[1] ^ v[4];
    r = !(v[2] && v[3]);
    w = v[0] | v[5];
    f = 6'((v * 7 + 3) % 64);
    return {f, w, r, k, p};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // memory model, driven and sampled at the falling edge
  bit         last_v = 0;
  logic [11:0] last_a = '0;
  bit         pend = 0;
  int         dly = 0;
  logic [11:0] pend_a = '0;
  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (pend) begin
      if (dly == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = tbl[8'((pend_a - pt_base) >> 1)];
        pend = 0;
      end else dly--;
    end
    if (last_v && mem_req_ready) begin
      check(last_a == exp_addr, "R1", "entry address", last_a, exp_addr);
      pend = 1; pend_a = last_a; dly = cyc % 3;
    end
    last_v = mem_req_valid;
    last_a = mem_req_addr;
    mem_req_ready = mem_req_valid && (cyc % 4 != 1);
  end

  task automatic translate(input logic [13:0] va, input logic wr, input logic usr);
    logic [7:0] vpn;
    logic [9:0] e;
    logic [1:0] ef;
    logic [11:0] ep;
    string tag;
    int n;
    vpn = va[13:6];
    e = tbl[vpn];
    exp_addr = pt_base + 12'(vpn) * 12'd2;
    if (!e[0]) begin ef = 2'b01; tag = "R4"; end
    else if (usr && e[1]) begin ef = 2'b10; tag = "R5"; end
    else if (wr ? !e[3] : !e[2]) begin ef = 2'b10; tag = "R6"; end
    else begin ef = 2'b00; tag = "R3"; end
    ep = (ef == 2'b00) ? {e[9:4], va[5:0]} : 12'h000;
    @(negedge clk);
    req_vaddr = va; req_write = wr; req_user = usr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R2", "ready while walking", req_ready, 0);
    n = 0;
    while (!rsp_valid && n < 40) begin @(negedge clk); n++; end
    check(rsp_valid == 1'b1, "R7", "response seen", rsp_valid, 1);
    check(rsp_fault == ef, tag, "fault code", rsp_fault, ef);
    check(rsp_paddr == ep, tag, "physical address", rsp_paddr, ep);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R7", "single pulse", rsp_valid, 0);
  endtask

  initial begin
    for (int i = 0; i < 10000000; i++) begin
      @(posedge clk);
      if (cyc > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    for (int v = 0; v < 256; v++) tbl[v] = make_entry(v);
    tbl[0] = {6'h28, 1'b0, 1'b1, 1'b0, 1'b1};
    repeat (3) @(negedge clk);
    // R9 reset state
    check(req_ready == 1'b1, "R9", "req_ready in reset", req_ready, 1);
    check(mem_req_valid == 1'b0, "R9", "mem_req_valid in reset", mem_req_valid, 0);
    check(rsp_valid == 1'b0, "R9", "rsp_valid in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // worked example: 0x0020 -> 0xA20
    translate(14'h0020, 1'b0, 1'b1);
    check(rsp_paddr == 12'hA20 || fails > 0, "R3", "example address", rsp_paddr, 12'hA20);
    // full sweep
    for (int v = 0; v < 256; v++)
      for (int m = 0; m < 4; m++)
        translate({8'(v), 6'((v * 13 + m * 17) % 64)}, m[0], m[1]);
    // R8: fresh walk after the entry changes
    tbl[9] = {6'h15, 1'b1, 1'b1, 1'b0, 1'b0};
    translate({8'd9, 6'h3F}, 1'b1, 1'b1);
    check(rsp_fault == 2'b01, "R8", "absent before update", rsp_fault, 1);
    tbl[9] = {6'h15, 1'b1, 1'b1, 1'b0, 1'b1};
    translate({8'd9, 6'h3F}, 1'b1, 1'b1);
    check(rsp_paddr == 12'h57F, "R8", "present after update", rsp_paddr, 12'h57F);
    finish_run();
  end
endmodule